// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit of a non-pipelined 32-bit processor that takes several clock cycles per instruction. It steps through one state per clock edge and drives every datapath control line from the current state alone, so the outputs never depend on the opcode input directly. Each instruction begins with a shared fetch state and a shared decode state. After decode, the opcode selects one of several paths, and every path returns to fetch. Depending on the instruction, the full sequence takes 3 to 5 cycles.

The surrounding datapath holds the instruction register. The opcode field of that register feeds this block, and it stays stable from the end of fetch until the next fetch. Six instruction classes are supported: register-register ALU operations, load word, store word, branch-if-equal, jump and add-immediate. An opcode that does not match any of these sends the machine back to fetch and raises a one-cycle flag. The state code is exposed on an output.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, the state is 0 at once, without waiting for a clock edge. After reset is released, the first cycle is a fetch with illegal_o low.
- R2: State 0 (fetch) drives pc_write, mem_read and ir_write to 1, alu_src_b to 01, and iord, alu_src_a, alu_op and pc_src to 0. The next state is always 1.
- R3: State 1 (decode) drives alu_src_b to 11, with alu_src_a and alu_op at 0. The next state is chosen by the opcode: 100011 (load), 101011 (store) and 001000 (add-immediate) go to 2; 000000 (register op) goes to 6; 000100 (branch) goes to 8; 000010 (jump) goes to 9.
- R4: State 2 (address/add) drives alu_src_a=1, alu_src_b=10 and alu_op=00. From state 2, a load goes to 3, a store goes to 5 and an add-immediate goes to 10.
- R5: State 3 drives mem_read=1 and iord=1, then goes to state 4. State 4 drives reg_write=1, mem_to_reg=1 and reg_dst=0.
- R6: State 5 drives mem_write=1 and iord=1.
- R7: State 6 drives alu_src_a=1, alu_src_b=00 and alu_op=10, then goes to state 7. State 7 drives reg_write=1, reg_dst=1 and mem_to_reg=0.
- R8: State 8 drives alu_src_a=1, alu_src_b=00, alu_op=01, pc_src=01 and pc_write_cond=1.
- R9: State 9 drives pc_src=10 and pc_write=1.
- R10: State 10 (add-immediate completion) drives reg_write=1, with reg_dst=0, mem_to_reg=0 and alu_op=00.
- R11: States 4, 5, 7, 8, 9 and 10 return to 0. In every state, each control line that the state does not name is 0. Sequence lengths in cycles are: load 5, store 4, register op 4, add-immediate 4, branch 3, jump 3.
- R12: Any other opcode seen in decode sends the machine to state 0. illegal_o is 1 during exactly that next cycle and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| pc_write_o | output | 1 | Unconditional PC load |
| pc_write_cond_o | output | 1 | PC load gated by ALU zero |
| iord_o | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_read_o | output | 1 | Memory read strobe |
| mem_write_o | output | 1 | Memory write strobe |
| ir_write_o | output | 1 | Instruction register load |
| mem_to_reg_o | output | 1 | Register write data select: 1 memory data |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_src_a_o | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_src_b_o | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_write_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Destination register select: 1 rd, 0 rt |
| state_o | output | 4 | Current state code |
| illegal_o | output | 1 | One-cycle flag after an unknown opcode in decode |

## Verification
The hardest condition to reach is an asynchronous reset that arrives partway through a long path, such as the memory read of a load. From the ports, the only way to create it is to issue the load and count cycles until state 3 is reached. The bench does this on purpose and then confirms that the machine lands in fetch at once. A second hard condition is two unknown opcodes in a row, which checks that the illegal flag falls after one cycle even when it is triggered again straight away. The bench drives this pattern directly. It also mixes random illegal opcodes into a seeded random instruction stream.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int unsigned ST_W = 4;
  localparam int unsigned OP_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LD_MEM  = 4'd3,
    ST_LD_WB   = 4'd4,
    ST_ST_MEM  = 4'd5,
    ST_R_EXEC  = 4'd6,
    ST_R_WB    = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9,
    ST_ADDI_WB = 4'd10
  } state_e;

  typedef enum logic [2:0] {
    CLS_RTYPE,
    CLS_LOAD,
    CLS_STORE,
    CLS_BEQ,
    CLS_JUMP,
    CLS_ADDI,
    CLS_BAD
  } opclass_e;

  typedef struct packed {
    logic       pc_write;
    logic       pc_write_cond;
    logic       iord;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       mem_to_reg;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic       reg_write;
    logic       reg_dst;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_opclass.sv
module mc_ctrl_opclass
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output opclass_e        cls_o
);

  always_comb begin
    case (opcode_i)
      OPC_RTYPE: cls_o = CLS_RTYPE;
      OPC_LOAD:  cls_o = CLS_LOAD;
      OPC_STORE: cls_o = CLS_STORE;
      OPC_BEQ:   cls_o = CLS_BEQ;
      OPC_JUMP:  cls_o = CLS_JUMP;
      OPC_ADDI:  cls_o = CLS_ADDI;
      default:   cls_o = CLS_BAD;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  state_e   state_i,
  input  opclass_e cls_i,
  output state_e   next_o,
  output logic     bad_op_o
);

  always_comb begin
    next_o   = ST_FETCH;
    bad_op_o = 1'b0;
    case (state_i)
      ST_FETCH: next_o = ST_DECODE;
      ST_DECODE: begin
        case (cls_i)
          CLS_LOAD, CLS_STORE, CLS_ADDI: next_o = ST_ADDR;
          CLS_RTYPE:                     next_o = ST_R_EXEC;
          CLS_BEQ:                       next_o = ST_BRANCH;
          CLS_JUMP:                      next_o = ST_JUMP;
          default: begin
            next_o   = ST_FETCH;
            bad_op_o = 1'b1;
          end
        endcase
      end
      ST_ADDR: begin
        case (cls_i)
          CLS_LOAD:  next_o = ST_LD_MEM;
          CLS_STORE: next_o = ST_ST_MEM;
          CLS_ADDI:  next_o = ST_ADDI_WB;
          default:   next_o = ST_FETCH;
        endcase
      end
      ST_LD_MEM: next_o = ST_LD_WB;
      ST_R_EXEC: next_o = ST_R_WB;
      default:   next_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  // don't-care lines are driven low
  always_comb begin
    ctrl_o = '0;
    case (state_i)
      ST_FETCH: begin
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.ir_write  = 1'b1;
        ctrl_o.alu_src_b = 2'b01;
      end
      ST_DECODE: ctrl_o.alu_src_b = 2'b11;
      ST_ADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = 2'b10;
      end
      ST_LD_MEM: begin
        ctrl_o.mem_read = 1'b1;
        ctrl_o.iord     = 1'b1;
      end
      ST_LD_WB: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      ST_ST_MEM: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.iord      = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = 2'b10;
      end
      ST_R_WB: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_src_a     = 1'b1;
        ctrl_o.alu_op        = 2'b01;
        ctrl_o.pc_src        = 2'b01;
        ctrl_o.pc_write_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl_o.pc_src   = 2'b10;
        ctrl_o.pc_write = 1'b1;
      end
      ST_ADDI_WB: ctrl_o.reg_write = 1'b1;
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic            pc_write_o,
  output logic            pc_write_cond_o,
  output logic            iord_o,
  output logic            mem_read_o,
  output logic            mem_write_o,
  output logic            ir_write_o,
  output logic            mem_to_reg_o,
  output logic [1:0]      pc_src_o,
  output logic [1:0]      alu_op_o,
  output logic            alu_src_a_o,
  output logic [1:0]      alu_src_b_o,
  output logic            reg_write_o,
  output logic            reg_dst_o,
  output logic [ST_W-1:0] state_o,
  output logic            illegal_o
);

  state_e   state_q, state_d;
  opclass_e cls;
  logic     bad_op, illegal_q;
  ctrl_t    ctrl;

  mc_ctrl_opclass u_cls (.opcode_i(opcode_i), .cls_o(cls));

  mc_ctrl_next u_next (
    .state_i (state_q),
    .cls_i   (cls),
    .next_o  (state_d),
    .bad_op_o(bad_op)
  );

  mc_ctrl_decode u_dec (.state_i(state_q), .ctrl_o(ctrl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FETCH;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= bad_op;
    end
  end

  assign state_o         = state_q;
  assign illegal_o       = illegal_q;
  assign pc_write_o      = ctrl.pc_write;
  assign pc_write_cond_o = ctrl.pc_write_cond;
  assign iord_o          = ctrl.iord;
  assign mem_read_o      = ctrl.mem_read;
  assign mem_write_o     = ctrl.mem_write;
  assign ir_write_o      = ctrl.ir_write;
  assign mem_to_reg_o    = ctrl.mem_to_reg;
  assign pc_src_o        = ctrl.pc_src;
  assign alu_op_o        = ctrl.alu_op;
  assign alu_src_a_o     = ctrl.alu_src_a;
  assign alu_src_b_o     = ctrl.alu_src_b;
  assign reg_write_o     = ctrl.reg_write;
  assign reg_dst_o       = ctrl.reg_dst;

  a_r2_fetch_to_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0) |=> (state_o == 4'd1));
  a_r2_fetch_loads_ir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0) |-> (ir_write_o && pc_write_o && mem_read_o));
  a_r5_load_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd3) |=> (state_o == 4'd4));
  a_r7_rtype_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd6) |=> (state_o == 4'd7));
  a_r8_cond_only_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_write_cond_o |-> (state_o == 4'd8));
  a_r11_tail_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd9, 4'd10}) |=> (state_o == 4'd0));
  a_r11_mem_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_read_o && mem_write_o));
  a_r12_illegal_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (state_o == 4'd0));
  a_r12_illegal_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

endmodule

// File: tb/mc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_test;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [5:0] opcode_i;
  logic       pc_write_o, pc_write_cond_o, iord_o, mem_read_o, mem_write_o;
  logic       ir_write_o, mem_to_reg_o, alu_src_a_o, reg_write_o, reg_dst_o, illegal_o;
  logic [1:0] pc_src_o, alu_op_o, alu_src_b_o;
  logic [3:0] state_o;

  int errs = 0;
  int checks = 0;
  int m_state = 0;
  bit m_ill = 1'b0;

  always #2 clk_i = ~clk_i;

  mc_ctrl_fsm uut (.*);

  logic [15:0] act;
  assign act = {pc_write_o, pc_write_cond_o, iord_o, mem_read_o, mem_write_o, ir_write_o,
                mem_to_reg_o, pc_src_o, alu_op_o, alu_src_a_o, alu_src_b_o, reg_write_o, reg_dst_o};

  // {pcw,pcwc,iord,mr,mw,irw,m2r,pcs[2],aluop[2],srca,srcb[2],rw,rd}
  function automatic logic [15:0] exp_ctrl(int s);
    case (s)
      0:  return 16'b1_0_0_1_0_1_0_00_00_0_01_0_0;
      1:  return 16'b0_0_0_0_0_0_0_00_00_0_11_0_0;
      2:  return 16'b0_0_0_0_0_0_0_00_00_1_10_0_0;
      3:  return 16'b0_0_1_1_0_0_0_00_00_0_00_0_0;
      4:  return 16'b0_0_0_0_0_0_1_00_00_0_00_1_0;
      5:  return 16'b0_0_1_0_1_0_0_00_00_0_00_0_0;
      6:  return 16'b0_0_0_0_0_0_0_00_10_1_00_0_0;
      7:  return 16'b0_0_0_0_0_0_0_00_00_0_00_1_1;
      8:  return 16'b0_1_0_0_0_0_0_01_01_1_00_0_0;
      9:  return 16'b1_0_0_0_0_0_0_10_00_0_00_0_0;
      10: return 16'b0_0_0_0_0_0_0_00_00_0_00_1_0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R2";   1: return "R3";  2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R8";   9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic bit is_legal(logic [5:0] op);
    return op inside {6'b000000, 6'b000010, 6'b000100, 6'b001000, 6'b100011, 6'b101011};
  endfunction

  function automatic int exp_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011 || op == 6'b001000) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 0;
      end
      2: return (op == 6'b100011) ? 3 : (op == 6'b101011) ? 5 : (op == 6'b001000) ? 10 : 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000, 6'b001000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int a, int e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  // check outputs of current cycle, advance model, wait one clock
  task automatic step();
    int nxt;
    chk(state_o == 4'(m_state), "R11", "state", int'(state_o), m_state);
    chk(act == exp_ctrl(m_state), req_of(m_state), "ctrl", int'(act), int'(exp_ctrl(m_state)));
    chk(illegal_o == m_ill, "R12", "illegal", int'(illegal_o), int'(m_ill));
    nxt = exp_next(m_state, opcode_i);
    m_ill = (m_state == 1) && !is_legal(opcode_i);
    m_state = nxt;
    @(negedge clk_i);
  endtask

  task automatic run_instr(logic [5:0] op);
    int n = 0;
    opcode_i = op;
    do begin
      step();
      n++;
    end while (m_state != 0);
    chk(n == exp_len(op), "R11", "length", n, exp_len(op));
  endtask

  function automatic logic [5:0] rand_bad();
    logic [5:0] v;
    do v = 6'($urandom); while (is_legal(v));
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [5:0] ops [6];
    ops = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010, 6'b001000};
    void'($urandom(32'd4242));
    rst_ni = 1'b0;
    opcode_i = 6'b100011;
    repeat (3) @(negedge clk_i);
    chk(state_o == 4'd0, "R1", "reset state", int'(state_o), 0);
    chk(illegal_o == 1'b0, "R1", "reset illegal", int'(illegal_o), 0);
    rst_ni = 1'b1;
    m_state = 0; m_ill = 1'b0;

    // R3 dispatch of every class
    foreach (ops[i]) run_instr(ops[i]);
    // R12 illegal, then back-to-back illegal
    run_instr(6'b111111);
    run_instr(6'b000001);
    run_instr(6'b110000);
    run_instr(6'b001000);

    // R1 async reset in the middle of a load (state 3)
    opcode_i = 6'b100011;
    step(); step(); step();
    chk(state_o == 4'd3, "R5", "pre-reset state", int'(state_o), 3);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(state_o == 4'd0, "R1", "async reset", int'(state_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_state = 0; m_ill = 1'b0;
    run_instr(6'b000100);

    // random stream
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 9) == 0) run_instr(rand_bad());
      else run_instr(ops[$urandom_range(0, 5)]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule